// File: doc/BRIEF.md
# Output Voltage Target Slew Sequencer

This block produces the digital voltage target for a multiphase buck regulator. After power-on reset it waits until the bias supply is healthy and the enable pin is high. It then turns on the reference. Once the reference reports ready, it lets the regulator switch and walks the target code one DAC step at a time toward a programmed code. The step period comes from a prescaler. A single register bit selects the slow period or the fast period, and the slow period is a fixed multiple of the fast one.

While the target is moving, and for a fixed hold-off time after the last step, the interrupt request is masked. Once the hold-off ends, a latched fault or a live alarm drives the open-drain interrupt low. During a downward ramp the block raises a pulse-skip control output, so the power stage runs forced PWM and actively discharges the output. In every other case that output stays low and pulse skipping is allowed.

Configuration arrives on a small valid/ready write port. The port never applies back-pressure: `wr_ready` is always high, and every cycle with `wr_valid` high performs one write.

Top module: `vsq_seq`

## Requirements
- R1: While `rst_n` is low and just after it rises, `vtarget` is 0, and `ref_on`, `sw_en`, `skip_hi` and `int_pull` are 0. The slew bit resets to slow, the target register resets to `BOOT_CODE`, and the fault latch is cleared.
- R2: `ref_on` is 1 only while `uvlo_ok` and `en` were both high at the previous clock edge. `sw_en` stays 0 until `ref_ready` has been seen with `ref_on` high.
- R3: One edge after `ref_ready` is sampled high, `sw_en` rises. `vtarget` then ramps from 0 to the target register, which holds `BOOT_CODE` after reset.
- R4: A write with `wr_sel`=0 sets the slew bit from `wr_data[0]`, where 1 means fast and 0 means slow. A write with `wr_sel`=1 sets the target code. A fast ramp steps every `FAST_DIV` cycles and a slow ramp every `FAST_DIV*SLOW_RATIO` cycles.
- R5: While switching is enabled, `vtarget` changes by at most one LSB per cycle.
- R6: `skip_hi` is 1 while the ramp is stepping downward, and 0 otherwise.
- R7: `int_pull` is 0 while the ramp moves. It stays 0 for `CLK_MHZ*HOLD_NS/1000` clock edges after the final step.
- R8: Outside the masked window, `int_pull` equals the fault latch OR `alarm`. A one-cycle `fault` pulse keeps the latch set until the next reset.
- R9: A target written mid-ramp takes effect at the next step. The direction and `skip_hi` follow the new code from that step on.
- R10: When `uvlo_ok` or `en` falls, `ref_on` and `sw_en` drop one edge later, and `vtarget` returns to 0 one edge after that.
- R11: `wr_ready` is always 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Power-on reset, active low |
| uvlo_ok | input | 1 | Bias supply above its lockout threshold |
| en | input | 1 | Regulator enable |
| ref_ready | input | 1 | Reference is in regulation |
| wr_valid | input | 1 | Register write strobe |
| wr_ready | output | 1 | Write accepted (always 1) |
| wr_sel | input | 1 | 0: slew bit, 1: target code |
| wr_data | input | DAC_W | Write data |
| fault | input | 1 | Fault event (latched) |
| alarm | input | 1 | Alarm condition (level) |
| vtarget | output | DAC_W | Stepped DAC target code |
| ref_on | output | 1 | Reference power-up request |
| sw_en | output | 1 | Switching enable |
| skip_hi | output | 1 | High forces PWM, low allows pulse skipping |
| int_pull | output | 1 | Pull the open-drain interrupt low |

## Verification
The hardest situation to reach is a retarget that lands while a ramp is in flight and reverses its direction. The bench first selects the fast rate and sends the target well above the present code. After watching a few upward steps, it writes a code below the start point. It then checks that the overshoot past the code seen at the write is at most two steps, that `skip_hi` rises, and that the ramp settles at the new code. The hold-off count is measured by keeping `alarm` high across the boot ramp and counting edges from the last step until the interrupt appears.

// File: rtl/vsq_pkg.sv
package vsq_pkg;
  typedef enum logic [1:0] {PH_OFF, PH_REF, PH_RUN} phase_t;
  localparam logic SEL_SLEW = 1'b0;
  localparam logic SEL_CODE = 1'b1;
endpackage

// File: rtl/vsq_regs.sv
module vsq_regs #(
  parameter int DAC_W = 8,
  parameter logic [DAC_W-1:0] BOOT_CODE = 8'd20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_valid,
  input  logic             wr_sel,
  input  logic [DAC_W-1:0] wr_data,
  input  logic             fault,
  output logic             fast_sel,
  output logic [DAC_W-1:0] code,
  output logic             fault_q
);
  import vsq_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fast_sel <= 1'b0;
      code     <= BOOT_CODE;
      fault_q  <= 1'b0;
    end else begin
      if (fault) fault_q <= 1'b1;
      if (wr_valid) begin
        if (wr_sel == SEL_SLEW) fast_sel <= wr_data[0];
        else                    code     <= wr_data;
      end
    end
  end
endmodule

// File: rtl/vsq_prescale.sv
module vsq_prescale #(
  parameter int FAST_DIV   = 2,
  parameter int SLOW_RATIO = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic fast,
  output logic tick
);
  localparam int SLOW_DIV = FAST_DIV * SLOW_RATIO;
  localparam int CW = (SLOW_DIV < 2) ? 1 : $clog2(SLOW_DIV);

  logic [CW-1:0] cnt;
  logic [CW-1:0] lim;

  assign lim  = fast ? CW'(FAST_DIV - 1) : CW'(SLOW_DIV - 1);
  assign tick = run && (cnt >= lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (!run || tick) cnt <= '0;
    else                   cnt <= cnt + CW'(1);
  end
endmodule

// File: rtl/vsq_ramp.sv
module vsq_ramp #(
  parameter int DAC_W    = 8,
  parameter int HOLD_CYC = 400
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active,
  input  logic [DAC_W-1:0] code,
  input  logic             tick,
  output logic [DAC_W-1:0] cur,
  output logic             moving,
  output logic             skip_hi,
  output logic             blank
);
  localparam int HW = (HOLD_CYC < 1) ? 1 : $clog2(HOLD_CYC + 1);

  logic [DAC_W-1:0] goal;
  logic [HW-1:0]    hold;

  assign moving  = (cur != goal);
  assign skip_hi = moving && (goal < cur);
  assign blank   = moving || (hold != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur  <= '0;
      goal <= '0;
      hold <= '0;
    end else if (!active) begin
      cur  <= '0;
      goal <= '0;
      hold <= '0;
    end else begin
      if (!moving || tick) goal <= code;
      if (moving && tick) begin
        if (goal > cur) cur <= cur + DAC_W'(1);
        else            cur <= cur - DAC_W'(1);
      end
      if (moving)              hold <= HW'(HOLD_CYC);
      else if (hold != '0)     hold <= hold - HW'(1);
    end
  end
endmodule

// File: rtl/vsq_seq.sv
module vsq_seq #(
  parameter int DAC_W      = 8,
  parameter logic [DAC_W-1:0] BOOT_CODE = 8'd20,
  parameter int FAST_DIV   = 2,
  parameter int SLOW_RATIO = 4,
  parameter int CLK_MHZ    = 100,
  parameter int HOLD_NS    = 4000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             uvlo_ok,
  input  logic             en,
  input  logic             ref_ready,
  input  logic             wr_valid,
  output logic             wr_ready,
  input  logic             wr_sel,
  input  logic [DAC_W-1:0] wr_data,
  input  logic             fault,
  input  logic             alarm,
  output logic [DAC_W-1:0] vtarget,
  output logic             ref_on,
  output logic             sw_en,
  output logic             skip_hi,
  output logic             int_pull
);
  import vsq_pkg::*;

  localparam int HOLD_CYC = (CLK_MHZ * HOLD_NS) / 1000;

  phase_t           phase;
  logic             fast_sel;
  logic [DAC_W-1:0] code;
  logic             fault_q;
  logic             tick;
  logic             moving;
  logic             blank;

  assign wr_ready = 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                phase <= PH_OFF;
    else if (!(uvlo_ok && en)) phase <= PH_OFF;
    else begin
      case (phase)
        PH_OFF:  phase <= PH_REF;
        PH_REF:  if (ref_ready) phase <= PH_RUN;
        default: phase <= PH_RUN;
      endcase
    end
  end

  assign ref_on   = (phase != PH_OFF);
  assign sw_en    = (phase == PH_RUN);
  assign int_pull = (fault_q || alarm) && !blank;

  vsq_regs #(.DAC_W(DAC_W), .BOOT_CODE(BOOT_CODE)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid && wr_ready),
    .wr_sel(wr_sel), .wr_data(wr_data), .fault(fault),
    .fast_sel(fast_sel), .code(code), .fault_q(fault_q)
  );

  vsq_prescale #(.FAST_DIV(FAST_DIV), .SLOW_RATIO(SLOW_RATIO)) u_pre (
    .clk(clk), .rst_n(rst_n), .run(moving), .fast(fast_sel), .tick(tick)
  );

  vsq_ramp #(.DAC_W(DAC_W), .HOLD_CYC(HOLD_CYC)) u_ramp (
    .clk(clk), .rst_n(rst_n), .active(sw_en), .code(code), .tick(tick),
    .cur(vtarget), .moving(moving), .skip_hi(skip_hi), .blank(blank)
  );
endmodule

// File: rtl/vsq_seq_chk.sv
module vsq_seq_chk #(
  parameter int DAC_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             uvlo_ok,
  input logic             en,
  input logic             sw_en,
  input logic             ref_on,
  input logic             skip_hi,
  input logic             int_pull,
  input logic             alarm,
  input logic             fault_q,
  input logic [DAC_W-1:0] vtarget
);
  AST_SWEN_NEEDS_REF: assert property (@(posedge clk) disable iff (!rst_n)
    sw_en |-> ref_on); // R2

  AST_REF_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    ref_on |-> $past(uvlo_ok && en)); // R2

  AST_ONE_LSB_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_en && $past(sw_en)) |-> (vtarget == $past(vtarget) ||
      vtarget == $past(vtarget) + DAC_W'(1) ||
      vtarget == $past(vtarget) - DAC_W'(1))); // R5

  AST_SKIP_ONLY_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    skip_hi |-> sw_en); // R6

  AST_INT_MASKED_ON_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_en && $past(sw_en) && vtarget != $past(vtarget)) |-> !int_pull); // R7

  AST_INT_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    int_pull |-> (fault_q || alarm)); // R8
endmodule

bind vsq_seq vsq_seq_chk #(.DAC_W(DAC_W)) u_chk (.*);

// File: tb/vsq_seq_tb.sv
module vsq_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 8;
  localparam int BOOT = 20;
  localparam int FDIV = 2;
  localparam int SDIV = FDIV * 4;
  localparam int HOLD = 5 * 4000 / 1000;
  localparam int NVEC = 5;
  // {fast, code}
  localparam logic [8:0] VEC [NVEC] = '{
    {1'b0, 8'd26}, {1'b1, 8'd31}, {1'b1, 8'd24}, {1'b0, 8'd19}, {1'b1, 8'd23}
  };

  logic clk = 0, rst_n = 0, uvlo_ok = 0, en = 0, ref_ready = 0;
  logic wr_valid = 0, wr_sel = 0, fault = 0, alarm = 0;
  logic [DW-1:0] wr_data = '0;
  logic wr_ready, ref_on, sw_en, skip_hi, int_pull;
  logic [DW-1:0] vtarget;
  int n_checks = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vsq_seq #(.DAC_W(DW), .BOOT_CODE(8'(BOOT)), .FAST_DIV(FDIV), .SLOW_RATIO(4),
            .CLK_MHZ(5), .HOLD_NS(4000)) u_dut (
    .clk(clk), .rst_n(rst_n), .uvlo_ok(uvlo_ok), .en(en), .ref_ready(ref_ready),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_sel(wr_sel), .wr_data(wr_data),
    .fault(fault), .alarm(alarm), .vtarget(vtarget), .ref_on(ref_on),
    .sw_en(sw_en), .skip_hi(skip_hi), .int_pull(int_pull));

  task automatic chk(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) begin @(posedge clk); @(negedge clk); end
  endtask

  task automatic wr(input logic sel, input int data);
    wr_sel = sel; wr_data = DW'(data); wr_valid = 1;
    cyc(1);
    wr_valid = 0;
  endtask

  // follow the ramp to code; check step size, direction, skip, spacing
  task automatic follow(input int code, input int iv, input bit up, input string fin);
    int last = -1, t = 0, prev;
    logic pskip;
    while (int'(vtarget) != code && t < 3000) begin
      prev = int'(vtarget); pskip = skip_hi;
      cyc(1); t++;
      if (int'(vtarget) != prev) begin
        chk("R5 step size", int'(vtarget) - prev, up ? 1 : -1);
        chk("R6 skip during ramp", int'(pskip), up ? 0 : 1);
        if (last >= 0) chk("R4 step spacing", t - last, iv);
        last = t;
      end
    end
    chk(fin, int'(vtarget), code);
    chk("R6 skip low after ramp", int'(skip_hi), 0);
  endtask

  task automatic report;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    int cnt;
    int prevc;
    int v;
    int peak;
    bit seen;
    cyc(3);
    // R1 reset state
    chk("R1 vtarget", int'(vtarget), 0);
    chk("R1 ref_on", int'(ref_on), 0);
    chk("R1 sw_en", int'(sw_en), 0);
    chk("R1 skip_hi", int'(skip_hi), 0);
    chk("R1 int_pull", int'(int_pull), 0);
    chk("R11 wr_ready", int'(wr_ready), 1);
    rst_n = 1; cyc(1);
    chk("R1 after release", int'(ref_on | sw_en | int_pull), 0);

    // R2 gating
    en = 1; cyc(5);
    chk("R2 ref off without uvlo", int'(ref_on), 0);
    uvlo_ok = 1; cyc(1);
    chk("R2 ref on", int'(ref_on), 1);
    cyc(5);
    chk("R2 no switching before ref ready", int'(sw_en), 0);
    ref_ready = 1; cyc(1);
    chk("R3 sw_en rises", int'(sw_en), 1);
    cyc(3);
    alarm = 1; #1;
    chk("R7 int masked on ramp", int'(int_pull), 0);
    follow(BOOT, SDIV, 1'b1, "R3 boot code reached");
    cnt = 0;
    while (!int_pull && cnt < 500) begin cyc(1); cnt++; end
    chk("R7 hold-off edges", cnt, HOLD);
    alarm = 0; #1;
    chk("R8 alarm drop clears int", int'(int_pull), 0);

    // vector table
    prevc = BOOT;
    for (int k = 0; k < NVEC; k++) begin
      wr(1'b0, int'(VEC[k][8]));
      wr(1'b1, int'(VEC[k][7:0]));
      follow(int'(VEC[k][7:0]), VEC[k][8] ? FDIV : SDIV,
             int'(VEC[k][7:0]) > prevc, "R4 table final code");
      prevc = int'(VEC[k][7:0]);
    end

    // R9 mid-ramp reversal
    wr(1'b1, 60);
    cnt = 0;
    while (int'(vtarget) < 26 && cnt < 200) begin cyc(1); cnt++; end
    v = int'(vtarget); peak = v; seen = 0;
    wr(1'b1, 20);
    cnt = 0;
    while (int'(vtarget) != 20 && cnt < 500) begin
      if (skip_hi) seen = 1;
      if (int'(vtarget) > peak) peak = int'(vtarget);
      cyc(1); cnt++;
    end
    chk("R9 overshoot bound", int'(peak <= v + 2), 1);
    chk("R9 skip after reversal", int'(seen), 1);
    chk("R9 new code reached", int'(vtarget), 20);

    // R8 fault latch
    cyc(HOLD + 5);
    fault = 1; cyc(1); fault = 0; cyc(10);
    chk("R8 fault latched", int'(int_pull), 1);

    // R10 disable
    en = 0; cyc(1);
    chk("R10 sw_en off", int'(sw_en), 0);
    chk("R10 ref off", int'(ref_on), 0);
    cyc(2);
    chk("R10 vtarget zero", int'(vtarget), 0);
    chk("R8 latch held while off", int'(int_pull), 1);

    // R1 / R8 power-on reset clears the latch
    rst_n = 0; cyc(1); rst_n = 1; cyc(1);
    chk("R8 reset clears latch", int'(int_pull), 0);
    done = 1;
    report();
  end

  initial begin
    for (int i = 0; i < 150000; i++) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
    end
  end
endmodule